// File: doc/BRIEF.md
# Second Operand Shifter Rotator

This block forms the right-hand operand of a data-processing datapath, together with the carry bit that the shifter produces. It has two modes. In constant mode, a 12-bit field encodes an 8-bit pattern and a 4-bit rotate count, and the block expands that pair into a full 32-bit word. In register mode, a register value is shifted or rotated. The amount comes either from a 5-bit field of the instruction or from the low byte of a second register.

Register reads and the ALU are outside the block. The result and the carry are captured in an output register that is cleared by an asynchronous active-low reset, so they appear one clock after the inputs. All widths are parameters, and their relations are checked at elaboration.

Top module: `sop_shift_rotate`

## Requirements
- R1: While `rst_n` is low, `operand` is 0 and `carry_out` is 0.
- R2: `operand` and `carry_out` reflect the inputs sampled at the previous rising clock edge (one cycle latency).
- R3: With `imm_mode`=1, `imm_field[11:8]` is a count p and `imm_field[7:0]` is a pattern v. `operand` is v, zero-extended to 32 bits and rotated right by 2*p. `shift_kind`, `amt_sel_reg`, `amt_field` and `amt_reg_byte` have no effect in this mode.
- R4: With `imm_mode`=1, `carry_out` equals `carry_in` when p is 0, and equals bit 31 of the new `operand` otherwise.
- R5: With `imm_mode`=0, `shift_kind` selects the operation: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. The amount n is `amt_field` when `amt_sel_reg`=0 and `amt_reg_byte` when `amt_sel_reg`=1.
- R6: With `imm_mode`=0 and n=0, for every kind, `operand` equals `reg_value` and `carry_out` equals `carry_in`.
- R7: Logical left by n in 1..31 fills zeros at the bottom, and `carry_out` is bit 32-n of `reg_value`.
- R8: Logical right by n in 1..31 fills zeros at the top. Arithmetic right fills copies of bit 31. For both, `carry_out` is bit n-1 of `reg_value`.
- R9: Rotate right moves the bits leaving bit 0 back in at bit 31, using n modulo 32. A nonzero multiple of 32 leaves the value unchanged and sets `carry_out` to bit 31. In all nonzero cases, `carry_out` equals bit 31 of `operand`.
- R10: For logical shifts, n=32 gives `operand` 0, with `carry_out` equal to bit 0 (left) or bit 31 (right) of `reg_value`. n above 32 gives `operand` 0 and `carry_out` 0.
- R11: Arithmetic right with n of 32 or more gives every bit of `operand` and `carry_out` equal to bit 31 of `reg_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge captures the result |
| rst_n | input | 1 | Asynchronous reset, active low |
| imm_mode | input | 1 | 1 = expand constant field, 0 = transform register value |
| imm_field | input | 12 | Rotate count (upper 4 bits) and pattern (lower 8 bits) |
| reg_value | input | 32 | Value to be shifted or rotated |
| shift_kind | input | 2 | Operation code for register mode |
| amt_sel_reg | input | 1 | 1 = amount from `amt_reg_byte`, 0 = from `amt_field` |
| amt_field | input | 5 | Amount held in the instruction |
| amt_reg_byte | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Registered operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The clocked properties assume that every input holds a known level at each rising edge. They also assume that reset is released between edges, so the first captured vector is the first one that counts. The stimulus drives inputs only on falling edges, holds them for a full cycle, and never leaves any input undriven.

The same properties cover both amount sources and every operation code. The scoreboard also steers amounts into the bands 0, 1..31, exactly 32 and 33..255, so that the saturating and modulo paths are hit as well as the common ones.

// File: rtl/sop_pkg.sv
package sop_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

endpackage

// File: rtl/sop_barrel.sv
// Logarithmic shifter: one stage per amount bit, tracking the last bit out.
module sop_barrel
   import sop_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  shift_kind_e       kind,
   input  logic [SH_W-1:0]   amt,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);

   if ((1 << SH_W) != DATA_W) begin : g_bad_width
      $error("sop_barrel: DATA_W must be a power of two");
   end

   function automatic logic [DATA_W:0] step_f(input logic [DATA_W-1:0] w,
                                              input shift_kind_e kind_i,
                                              input int d,
                                              input logic fill);
      logic [DATA_W-1:0] o;
      logic c;
      case (kind_i)
         SK_LSL: begin
            o = w << d;
            c = w[DATA_W-d];
         end
         SK_LSR: begin
            o = w >> d;
            c = w[d-1];
         end
         SK_ASR: begin
            o = w >> d;
            if (fill) o = o | ~({DATA_W{1'b1}} >> d);
            c = w[d-1];
         end
         default: begin
            o = (w >> d) | (w << (DATA_W - d));
            c = w[d-1];
         end
      endcase
      return {c, o};
   endfunction

   for (genvar k = 0; k < SH_W; k++) begin : g_st
      localparam int D = 1 << k;
      logic [DATA_W-1:0] w_in, w_out;
      logic              c_in, c_out;
      if (k == 0) begin : g_first
         assign w_in = src;
         assign c_in = cin;
      end else begin : g_next
         assign w_in = g_st[k-1].w_out;
         assign c_in = g_st[k-1].c_out;
      end
      assign {c_out, w_out} = amt[k] ? step_f(w_in, kind, D, src[DATA_W-1])
                                     : {c_in, w_in};
   end

   assign res  = g_st[SH_W-1].w_out;
   assign cout = g_st[SH_W-1].c_out;

endmodule

// File: rtl/sop_range_fix.sv
// Corrects the barrel result for register amounts at or beyond the word width.
module sop_range_fix
   import sop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              src_lsb,
   input  logic              src_msb,
   input  logic [DATA_W-1:0] b_res,
   input  logic              b_cout,
   output logic [DATA_W-1:0] res,
   output logic              cout
);

   if (AMT_W <= SH_W) begin : g_bad_amt
      $error("sop_range_fix: AMT_W must exceed the barrel amount width");
   end

   logic over, exact, low_zero;

   assign over     = |amt[AMT_W-1:SH_W];
   assign exact    = (amt == AMT_W'(DATA_W));
   assign low_zero = (amt[SH_W-1:0] == '0);

   always_comb begin
      res  = b_res;
      cout = b_cout;
      if (over) begin
         case (kind)
            SK_LSL: begin
               res  = '0;
               cout = exact & src_lsb;
            end
            SK_LSR: begin
               res  = '0;
               cout = exact & src_msb;
            end
            SK_ASR: begin
               res  = {DATA_W{src_msb}};
               cout = src_msb;
            end
            default: begin
               res  = b_res;
               cout = low_zero ? src_msb : b_cout;
            end
         endcase
      end
   end

endmodule

// File: rtl/sop_shift_rotate.sv
module sop_shift_rotate
   import sop_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_VAL_W = 8,
   parameter int IMM_POS_W = 4,
   parameter int AMT_REG_W = 8,
   parameter bit OUT_REG   = 1'b1,
   localparam int SH_W     = $clog2(DATA_W),
   localparam int IMM_W    = IMM_VAL_W + IMM_POS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              imm_mode,
   input  logic [IMM_W-1:0]  imm_field,
   input  logic [DATA_W-1:0] reg_value,
   input  logic [1:0]        shift_kind,
   input  logic              amt_sel_reg,
   input  logic [SH_W-1:0]   amt_field,
   input  logic [AMT_REG_W-1:0] amt_reg_byte,
   input  logic              carry_in,
   output logic [DATA_W-1:0] operand,
   output logic              carry_out
);

   if (IMM_POS_W + 1 != SH_W) begin : g_bad_pos
      $error("sop_shift_rotate: twice the position range must span DATA_W");
   end
   if (IMM_VAL_W > DATA_W) begin : g_bad_val
      $error("sop_shift_rotate: pattern wider than the word");
   end
   if (AMT_REG_W > DATA_W) begin : g_bad_reg
      $error("sop_shift_rotate: register amount wider than the word");
   end

   shift_kind_e kind;
   assign kind = shift_kind_e'(shift_kind);

   // constant path: the pattern is rotated right by twice the count
   logic [IMM_POS_W-1:0] imm_pos;
   logic [DATA_W-1:0]    imm_ext, imm_res;
   logic                 imm_c;

   assign imm_pos = imm_field[IMM_W-1:IMM_VAL_W];
   assign imm_ext = DATA_W'(imm_field[IMM_VAL_W-1:0]);

   sop_barrel #(.DATA_W(DATA_W)) u_imm_rot (
      .src  (imm_ext),
      .kind (SK_ROR),
      .amt  ({imm_pos, 1'b0}),
      .cin  (carry_in),
      .res  (imm_res),
      .cout (imm_c)
   );

   // register path: select the amount, shift, then correct wide amounts
   logic [AMT_REG_W-1:0] amt_wide;
   logic [DATA_W-1:0]    sh_res, reg_res;
   logic                 sh_c, reg_c;

   assign amt_wide = amt_sel_reg ? amt_reg_byte : AMT_REG_W'(amt_field);

   sop_barrel #(.DATA_W(DATA_W)) u_reg_sh (
      .src  (reg_value),
      .kind (kind),
      .amt  (amt_wide[SH_W-1:0]),
      .cin  (carry_in),
      .res  (sh_res),
      .cout (sh_c)
   );

   sop_range_fix #(.DATA_W(DATA_W), .AMT_W(AMT_REG_W)) u_fix (
      .kind    (kind),
      .amt     (amt_wide),
      .src_lsb (reg_value[0]),
      .src_msb (reg_value[DATA_W-1]),
      .b_res   (sh_res),
      .b_cout  (sh_c),
      .res     (reg_res),
      .cout    (reg_c)
   );

   logic [DATA_W-1:0] op_d;
   logic              c_d;

   assign op_d = imm_mode ? imm_res : reg_res;
   assign c_d  = imm_mode ? imm_c   : reg_c;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            operand   <= '0;
            carry_out <= 1'b0;
         end else begin
            operand   <= op_d;
            carry_out <= c_d;
         end
      end

      // R3: rotation keeps the number of set pattern bits
      assert_imm_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
         imm_mode |=> $countones(operand) == $past($countones(imm_field[IMM_VAL_W-1:0])));

      // R4: count zero keeps the incoming carry
      assert_imm_cin_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (imm_mode && imm_field[IMM_W-1:IMM_VAL_W] == '0) |=> carry_out == $past(carry_in));

      // R4: nonzero count copies the top result bit to the carry
      assert_imm_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (imm_mode && imm_field[IMM_W-1:IMM_VAL_W] != '0) |=> carry_out == operand[DATA_W-1]);

      // R6: zero amount is an identity for value and carry
      assert_zero_amt_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_mode && amt_wide == '0) |=>
            (operand == $past(reg_value) && carry_out == $past(carry_in)));

      // R9: rotation keeps the population count
      assert_ror_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_mode && shift_kind == 2'd3) |=>
            $countones(operand) == $past($countones(reg_value)));

      // R10: logical left beyond the width clears value and carry
      assert_lsl_over_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_mode && shift_kind == 2'd0 && amt_wide > AMT_REG_W'(DATA_W)) |=>
            (operand == '0 && !carry_out));

      // R11: arithmetic right at or beyond the width saturates to the sign
      assert_asr_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_mode && shift_kind == 2'd2 && amt_wide >= AMT_REG_W'(DATA_W)) |=>
            (operand == {DATA_W{$past(reg_value[DATA_W-1])}} &&
             carry_out == $past(reg_value[DATA_W-1])));
   end else begin : g_comb
      assign operand   = op_d;
      assign carry_out = c_d;
   end

endmodule

// File: tb/tb_sop_shift_rotate.sv
`timescale 1ns/1ps
module tb_sop_shift_rotate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imm_mode = 1'b0;
   logic [11:0] imm_field = '0;
   logic [31:0] reg_value = '0;
   logic [1:0]  shift_kind = '0;
   logic        amt_sel_reg = 1'b0;
   logic [4:0]  amt_field = '0;
   logic [7:0]  amt_reg_byte = '0;
   logic        carry_in = 1'b0;
   logic [31:0] operand;
   logic        carry_out;

   always #5 clk = ~clk;

   sop_shift_rotate dut (
      .clk(clk), .rst_n(rst_n), .imm_mode(imm_mode), .imm_field(imm_field),
      .reg_value(reg_value), .shift_kind(shift_kind), .amt_sel_reg(amt_sel_reg),
      .amt_field(amt_field), .amt_reg_byte(amt_reg_byte), .carry_in(carry_in),
      .operand(operand), .carry_out(carry_out)
   );

   typedef struct {
      logic [31:0] op;
      logic        c;
      int          stamp;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // one bit per step; independent of the design's staged structure
   function automatic logic [32:0] ref_model(input logic im, input logic [11:0] f,
                                             input logic [31:0] r, input logic [1:0] k,
                                             input logic sel, input logic [4:0] af,
                                             input logic [7:0] ab, input logic ci);
      logic [31:0] v;
      logic        c;
      int          n;
      c = ci;
      if (im) begin
         v = {24'd0, f[7:0]};
         for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
         if (f[11:8] != 0) c = v[31];
      end else begin
         v = r;
         n = sel ? int'(ab) : int'(af);
         for (int i = 0; i < n; i++) begin
            case (k)
               2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
               2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
               2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
               default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
         end
      end
      return {c, v};
   endfunction

   task automatic drive(input logic im, input logic [11:0] f, input logic [31:0] r,
                        input logic [1:0] k, input logic sel, input logic [4:0] af,
                        input logic [7:0] ab, input logic ci, input string tag);
      exp_t e;
      logic [32:0] x;
      @(negedge clk);
      imm_mode = im; imm_field = f; reg_value = r; shift_kind = k;
      amt_sel_reg = sel; amt_field = af; amt_reg_byte = ab; carry_in = ci;
      x = ref_model(im, f, r, k, sel, af, ab, ci);
      e.op = x[31:0];
      e.c = x[32];
      e.stamp = cyc;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compare each expected item one edge after it was driven
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0 && sb[0].stamp < cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (operand !== e.op || carry_out !== e.c) begin
               n_bad++;
               $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                        e.tag, operand, carry_out, e.op, e.c);
            end
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1: reset state with busy inputs
      imm_mode = 1'b1; imm_field = 12'hFFF; carry_in = 1'b1; reg_value = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      n_vec++;
      if (operand !== 32'h0 || carry_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: operand=%h carry=%b expected operand=00000000 carry=0",
                  operand, carry_out);
      end
      rst_n = 1'b1;

      // R2: latency, back-to-back different results
      drive(1, 12'h0FF, '0, 0, 0, 0, 0, 0, "R2");
      drive(1, 12'h000, '0, 0, 0, 0, 0, 1, "R2");
      // R3/R4: constant expansion
      drive(1, 12'h4FF, 32'h1234_5678, 2'd1, 1, 5'd3, 8'd9, 1'b1, "R3");
      drive(1, 12'hF81, '0, 0, 0, 0, 0, 0, "R3");
      drive(1, 12'h1AB, '0, 0, 0, 0, 0, 0, "R4");
      drive(1, 12'h0C0, '0, 0, 0, 0, 0, 1, "R4");
      drive(1, 12'h102, '0, 0, 0, 0, 0, 1, "R4");
      // R6: zero amount, both sources, all kinds
      for (int k = 0; k < 4; k++) begin
         drive(0, '0, 32'h8000_0001, k[1:0], 0, 5'd0, 8'd0, 1'b1, "R6");
         drive(0, '0, 32'h7FFF_FFFE, k[1:0], 1, 5'd7, 8'd0, 1'b0, "R6");
      end
      // R5/R7: logical left
      drive(0, '0, 32'hC000_0003, 2'd0, 0, 5'd1, 8'd0, 0, "R7");
      drive(0, '0, 32'h0000_0001, 2'd0, 0, 5'd31, 8'd0, 0, "R7");
      drive(0, '0, 32'hFFFF_0000, 2'd0, 1, 5'd0, 8'd16, 0, "R5");
      // R8: right shifts
      drive(0, '0, 32'h8000_0001, 2'd1, 0, 5'd1, 8'd0, 0, "R8");
      drive(0, '0, 32'h8000_0000, 2'd2, 0, 5'd31, 8'd0, 0, "R8");
      drive(0, '0, 32'h8765_4321, 2'd2, 1, 5'd0, 8'd4, 1, "R8");
      // R9: rotate
      drive(0, '0, 32'h0000_0001, 2'd3, 0, 5'd1, 8'd0, 0, "R9");
      drive(0, '0, 32'h8000_0000, 2'd3, 1, 5'd0, 8'd32, 0, "R9");
      drive(0, '0, 32'h1234_5678, 2'd3, 1, 5'd0, 8'd68, 0, "R9");
      drive(0, '0, 32'h1234_5679, 2'd3, 1, 5'd0, 8'd224, 1, "R9");
      // R10: logical at and beyond the width
      drive(0, '0, 32'h0000_0001, 2'd0, 1, 5'd0, 8'd32, 0, "R10");
      drive(0, '0, 32'h8000_0000, 2'd1, 1, 5'd0, 8'd32, 0, "R10");
      drive(0, '0, 32'hFFFF_FFFF, 2'd0, 1, 5'd0, 8'd33, 1, "R10");
      drive(0, '0, 32'hFFFF_FFFF, 2'd1, 1, 5'd0, 8'd255, 1, "R10");
      // R11: arithmetic saturation
      drive(0, '0, 32'h8000_0000, 2'd2, 1, 5'd0, 8'd32, 0, "R11");
      drive(0, '0, 32'h7FFF_FFFF, 2'd2, 1, 5'd0, 8'd200, 1, "R11");

      // mixed traffic with amounts steered into each band
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] ab;
         int band;
         band = int'($urandom_range(0, 3));
         case (band)
            0: ab = 8'd0;
            1: ab = 8'($urandom_range(1, 31));
            2: ab = 8'd32;
            default: ab = 8'($urandom_range(33, 255));
         endcase
         drive(1'($urandom), 12'($urandom), $urandom, 2'($urandom), 1'($urandom),
               5'($urandom), ab, 1'($urandom), "R5");
      end

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule